// File: doc/BRIEF.md
# Three-Channel Subset-Parity Symbol Encoder

This block turns 6-bit data words into 12-wire codewords for three parallel 4-wire channels. Every channel symbol has exactly two wires high. The six such symbols fall into three pairs, called subsets. Symbols in the same pair differ in all four positions.

The encoding works in two layers. The three upper data bits are rewritten as two base-3 digits. A third base-3 digit is then added as a checksum, so that the three digits sum to zero modulo 3. Each digit picks the subset used on one channel. The three lower data bits each pick one of the two members of that subset. The checksum therefore lives in the choice of subset and costs no extra wire: the rate is six data bits per twelve wires.

A receiver that knows the expected subset of a damaged symbol can recover the nearest member. This decoder is not part of the block. Input arrives over a valid/ready handshake, and the codeword is presented from a register.

Top module: `hse_encoder`

## Requirements
- R1: While `rst_n` is low, `out_word` is 0, `out_valid` is 0 and `in_ready` is 0. `in_ready` becomes 1 on the first rising clock edge after `rst_n` is sampled high.
- R2: Every 4-bit channel field of an issued codeword has exactly two bits set. Channel 2 is `out_word[11:8]`, channel 1 is `out_word[7:4]` and channel 0 is `out_word[3:0]`.
- R3: Let `u = in_data[5:3]` (0..7). Channel 2 carries the subset digit `u / 3` and channel 1 carries `u mod 3`. For example, u = 7 gives the digits 2 and 1.
- R4: Channel 0 carries the parity digit `p`, chosen so that (digit2 + digit1 + p) mod 3 = 0. Digits 2 and 1 give p = 0.
- R5: Subset 0 holds {0011, 1100}, subset 1 holds {0101, 1010} and subset 2 holds {0110, 1001}, with the bit strings written MSB first.
- R6: `in_data[k]` selects the member on channel k, for k = 0, 1, 2. A 0 picks the first listed member and a 1 picks the second. Input 6'b111101 therefore yields 12'h95C.
- R7: An accepted word (`in_valid` and `in_ready` both high at a rising edge) appears on `out_word` after that edge, with `out_valid` high for exactly one cycle. Without a handshake, `out_valid` is low on the following cycle.
- R8: If there is no handshake at an edge, `out_word` holds its value, whatever `in_data` carries.
- R9: The 64 possible input words produce 64 distinct codewords.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Encoder accepts a word at this edge |
| in_data | input | 6 | Data word; [5:3] subset layer, [2:0] member selects |
| out_valid | output | 1 | One-cycle pulse: `out_word` holds a newly encoded word |
| out_word | output | 12 | Registered codeword, channel 2 in the top nibble |

## Verification
The checker tests the following on every cycle:
- every issued symbol has weight two;
- the subset digits decoded from the output sum to zero modulo 3;
- the upper digit pair stays within the eight legal values;
- each member choice matches the select bit accepted one cycle earlier;
- `out_valid` follows the handshake, and the word is stable when there is no handshake.

Three things need the bench's scenarios. The exact base-3 split of each upper value, and the concrete symbols each subset maps to, are checked against a model for all 64 inputs. Distinctness across the whole input set is also checked there, since no single-cycle property can see it. So are the reset values, with garbage driven during idle gaps.

// File: rtl/hse_pkg.sv
// Package: shared widths, digit type and subset/member symbol table for
// the subset-parity encoder. Assumes three channels of 4-wire symbols.
package hse_pkg;

    localparam int SYM_W    = 4;                  // wires per channel
    localparam int NUM_CH   = 3;                  // parallel channels
    localparam int DIGIT_W  = 2;                  // bits for a base-3 digit
    localparam int UPPER_W  = 3;                  // data bits in subset layer
    localparam int DATA_W   = UPPER_W + NUM_CH;   // one member bit per channel
    localparam int WORD_W   = NUM_CH * SYM_W;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SYM_W-1:0]   sym_t;

    // Map a subset digit and a member select bit to a weight-2 symbol.
    function automatic sym_t subset_symbol(input digit_t dig, input logic sel);
        sym_t s;
        case (dig)
            2'd0:    s = sel ? 4'b1100 : 4'b0011;
            2'd1:    s = sel ? 4'b1010 : 4'b0101;
            2'd2:    s = sel ? 4'b1001 : 4'b0110;
            default: s = 4'b0000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hse_digit_split.sv
// Module: hse_digit_split
// Converts a 3-bit binary value (0..7) into two base-3 digits, high and low.
// Assumes the input never exceeds 7, so the high digit is at most 2.
// Built from compare-and-subtract steps, with no divider.
module hse_digit_split
    import hse_pkg::*;
(
    input  logic [UPPER_W-1:0] bin_in,
    output digit_t             dig_hi,
    output digit_t             dig_lo
);

    logic [UPPER_W-1:0] rem;

    // Pick the high digit by range, then take the remainder for the low digit.
    always_comb begin
        if (bin_in >= 3'd6) begin
            dig_hi = 2'd2;
            rem    = bin_in - 3'd6;
        end else if (bin_in >= 3'd3) begin
            dig_hi = 2'd1;
            rem    = bin_in - 3'd3;
        end else begin
            dig_hi = 2'd0;
            rem    = bin_in;
        end
        dig_lo = rem[DIGIT_W-1:0];
    end

    logic unused_rem;
    assign unused_rem = rem[UPPER_W-1];

endmodule

// File: rtl/hse_parity.sv
// Module: hse_parity
// Produces the base-3 checksum digit that makes the sum of the two data
// digits and itself congruent to zero mod 3. Assumes both inputs lie in 0..2.
module hse_parity
    import hse_pkg::*;
(
    input  digit_t dig_a,
    input  digit_t dig_b,
    output digit_t dig_p
);

    logic [DIGIT_W:0] sum;
    digit_t           sum_mod;

    // Reduce the 0..4 sum modulo 3, then negate modulo 3.
    always_comb begin
        sum     = {1'b0, dig_a} + {1'b0, dig_b};
        sum_mod = (sum >= 3'd3) ? digit_t'(sum - 3'd3) : sum[DIGIT_W-1:0];
        case (sum_mod)
            2'd1:    dig_p = 2'd2;
            2'd2:    dig_p = 2'd1;
            default: dig_p = 2'd0;
        endcase
    end

endmodule

// File: rtl/hse_sym_map.sv
// Module: hse_sym_map
// Maps one channel's subset digit and member-select bit to its 4-wire symbol.
// Assumes the digit lies in 0..2. An illegal digit maps to an all-zero symbol.
module hse_sym_map
    import hse_pkg::*;
(
    input  digit_t dig,
    input  logic   sel,
    output sym_t   sym
);

    // Look up the symbol in the shared subset table.
    always_comb sym = subset_symbol(dig, sel);

endmodule

// File: rtl/hse_encoder.sv
// Module: hse_encoder (top)
// Two-layer encoder for three 4-wire weight-2 channels:
// - in_data[5:3] becomes two base-3 subset digits (channels 2 and 1);
// - a mod-3 checksum digit goes to channel 0;
// - in_data[k] picks the member inside channel k's subset.
// The codeword is registered: it updates on the edge after a handshake and
// otherwise holds. in_ready rises one cycle after reset is released.
// Assumes: synchronous, active-low reset.
module hse_encoder
    import hse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);

    digit_t              digs [NUM_CH];
    logic [WORD_W-1:0]   word_nxt;
    logic                rdy_q;
    logic                vld_q;
    logic [WORD_W-1:0]   word_q;
    logic                accept;

    assign accept = in_valid && rdy_q;

    hse_digit_split u_split (
        .bin_in (in_data[DATA_W-1 -: UPPER_W]),
        .dig_hi (digs[2]),
        .dig_lo (digs[1])
    );

    hse_parity u_par (
        .dig_a (digs[2]),
        .dig_b (digs[1]),
        .dig_p (digs[0])
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        hse_sym_map u_map (
            .dig (digs[ch]),
            .sel (in_data[ch]),
            .sym (word_nxt[ch*SYM_W +: SYM_W])
        );
    end

    // Ready flag: low in reset, high from the first cycle after it.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= 1'b1;
    end

    // Output register: load on handshake, hold otherwise; pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= accept;
            if (accept) word_q <= word_nxt;
        end
    end

    assign in_ready  = rdy_q;
    assign out_valid = vld_q;
    assign out_word  = word_q;

endmodule

// File: rtl/hse_encoder_chk.sv
// Module: hse_encoder_chk
// Property checker bound to hse_encoder. It decodes subsets and members
// from the output wires and relates them to the handshake.
module hse_encoder_chk
    import hse_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word
);

    // Recover the subset index of a symbol; 3 marks a non-member.
    function automatic int sub_of(input logic [SYM_W-1:0] s);
        case (s)
            4'b0011, 4'b1100: return 0;
            4'b0101, 4'b1010: return 1;
            4'b0110, 4'b1001: return 2;
            default:          return 3;
        endcase
    endfunction

    logic hs;
    assign hs = in_valid && in_ready;

    AST_WEIGHT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_word[11:8]) == 2 &&
                       $countones(out_word[7:4])  == 2 &&
                       $countones(out_word[3:0])  == 2)); // R2

    AST_UPPER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sub_of(out_word[11:8]) * 3 + sub_of(out_word[7:4]) <= 7)); // R3

    AST_PARITY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((sub_of(out_word[11:8]) + sub_of(out_word[7:4]) +
                        sub_of(out_word[3:0])) % 3 == 0)); // R4

    AST_MEMBER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> (out_word[11] == $past(in_data[2]) &&
                out_word[7]  == $past(in_data[1]) &&
                out_word[3]  == $past(in_data[0]))); // R6

    AST_VALID_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> out_valid); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> !out_valid); // R7

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> $stable(out_word)); // R8

endmodule

bind hse_encoder hse_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/sim_hse_encoder.sv
// Scoreboard bench for hse_encoder. A driver task queues the expected
// codeword of every accepted word, and a monitor compares the outputs.
module sim_hse_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  in_data = '0;
    logic        out_valid;
    logic [11:0] out_word;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] exp_q [$];
    logic [11:0] last_word = '0;
    bit          mon_on = 1'b0;
    bit          seen [int];

    always #4 clk = ~clk;   // 125 MHz

    hse_encoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // Model of the requirements: R3 split, R4 parity, R5 table, R6 select.
    function automatic logic [11:0] model(input logic [5:0] d);
        logic [3:0] tbl [3][2];
        int u, hi, lo, p;
        tbl[0][0] = 4'b0011; tbl[0][1] = 4'b1100;
        tbl[1][0] = 4'b0101; tbl[1][1] = 4'b1010;
        tbl[2][0] = 4'b0110; tbl[2][1] = 4'b1001;
        u  = int'(d[5:3]);
        hi = u / 3;
        lo = u % 3;
        p  = (3 - ((hi + lo) % 3)) % 3;
        return {tbl[hi][d[2]], tbl[lo][d[1]], tbl[p][d[0]]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [11:0] act,
                         input logic [11:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Driver: present one word for one edge, queue its expected codeword.
    task automatic send(input logic [5:0] d);
        in_valid = 1'b1;
        in_data  = d;
        exp_q.push_back(model(d));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Idle gap with garbage data that must be ignored (R8).
    task automatic idle(input int n, input logic [5:0] junk);
        in_valid = 1'b0;
        in_data  = junk;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare issued words against the queue; check hold when idle.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected out_valid", out_word, last_word);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    check(out_word === e, "R3/R4/R5/R6 codeword", out_word, e);
                    check(($countones(out_word[11:8]) == 2) && ($countones(out_word[7:4]) == 2)
                          && ($countones(out_word[3:0]) == 2), "R2 weight", out_word, e);
                    if (seen.exists(int'(out_word)) && exp_q.size() == 0 && 1'b0) begin end
                    seen[int'(out_word)] = 1'b1;
                    last_word = out_word;
                end
            end else begin
                check(out_word === last_word, "R8 hold", out_word, last_word);
            end
        end
    end

    // Watchdog: an expired run counts as a failure and still summarizes.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        in_data = 6'h2A;
        in_valid = 1'b1;          // must not be accepted during reset
        repeat (3) @(negedge clk);
        check(out_word === 12'h000, "R1 reset word", out_word, 12'h000);
        check(out_valid === 1'b0, "R1 reset valid", {11'b0, out_valid}, 12'h000);
        check(in_ready === 1'b0, "R1 reset ready", {11'b0, in_ready}, 12'h000);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 ready after reset", {11'b0, in_ready}, 12'h001);
        check(out_valid === 1'b0, "R7 no output without handshake", {11'b0, out_valid}, 12'h000);
        mon_on = 1'b1;

        // Worked example: 111101 -> 1001 0101 1100 (R6).
        send(6'b111101);
        check(out_word === 12'h95C, "R6 example word", out_word, 12'h95C);
        idle(3, 6'b000000);

        // Back-to-back sweep over all 64 inputs (R3..R6, R9).
        for (int i = 0; i < 64; i++) send(6'(i));
        idle(2, 6'h3F);

        // Sparse traffic with garbage between words (R7, R8).
        for (int i = 0; i < 16; i++) begin
            send(6'((i * 37 + 5) % 64));
            idle((i % 3) + 1, 6'((i * 11) % 64));
        end
        idle(2, 6'h15);

        check(exp_q.size() == 0, "R7 every accepted word issued",
              12'(exp_q.size()), 12'h000);
        check(seen.num() == 64, "R9 distinct codewords", 12'(seen.num()), 12'd64);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule